// File: doc/BRIEF.md
# Multi-wire TDM channel scheduler

This block collects one sample from each of a fixed set of channels at the start of a sample period. It then sends them out over several time-division-multiplexed output wires during the clock cycles of that period. The TDM factor is the system clock rate divided by the per-channel sample rate, and it sets the number of time slots on each wire. The block uses the smallest number of wires that can carry every channel. It spreads the channels evenly across those wires. All wires share a single valid flag and a single slot index.

A producer pulses the input strobe with every channel's sample on the wide input bus. The first slot appears on the outputs one clock later. A consumer downstream reads the slot index as the position within each wire, not as an absolute channel number. It rebuilds the absolute channel number as wire × channels-per-wire + index. A strobe that arrives too early does not disturb the period in progress. It is recorded on a sticky error flag.

The reset is asynchronous and active low. It is expected to be released synchronously to the clock by the reset logic around the block.

Top module: `tdm_sched`

## Requirements
- R1: During a period, `out_idx` reads 0, 1, …, CPW−1 on consecutive valid slots. Here NWIRE = ceil(NUM_CH/TDM) and CPW = ceil(NUM_CH/NWIRE). With a single wire the index equals the absolute channel number.
- R2: In slot k (0 ≤ k < CPW), wire w (`out_data[w*SW +: SW]`) carries channel w*CPW+k. Channel c is taken from `in_data[c*SW +: SW]`.
- R3: A wire/slot position whose channel number w*CPW+k is at or above NUM_CH is driven as zero, while valid stays high for that slot.
- R4: In slots CPW … TDM−1 of a period, and whenever no period is running, `out_valid` is low and `out_idx` and `out_data` are zero.
- R5: The first slot of a period is on the outputs in the cycle after the clock edge that accepts the strobe. The period lasts exactly TDM cycles. Without a new strobe, valid is low after it.
- R6: A strobe sampled at the edge where the last slot (TDM−1) of a period is being shown is accepted. Slot 0 of the new period follows with no gap.
- R7: A strobe sampled while a period is running and not at its last slot is ignored: the data of the running period continues unchanged. It sets `overrun`, which stays high until reset.
- R8: While reset is asserted, `out_valid`, `out_idx`, `out_data` and `overrun` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_strobe | input | 1 | Capture request for a new set of samples |
| in_data | input | NUM_CH*SW | One sample per channel, channel c at bits c*SW +: SW |
| out_valid | output | 1 | Shared valid flag for all wires |
| out_idx | output | max(1,clog2(CPW)) | Shared slot index within each wire |
| out_data | output | NWIRE*SW | Wire w at bits w*SW +: SW |
| overrun | output | 1 | Sticky flag: a strobe arrived during a running period |

## Verification
The bench builds four instances side by side, each with an 8-bit sample width. The configurations are 2 channels at TDM factor 3 (one wire with an idle slot), 4 channels at factor 3 (two wires, each with an idle slot), and 5 channels at factor 3 (two full wires, one position past the last channel). The fourth is 3 channels at factor 1, which gives one slot on three wires and a strobe that may come on every cycle. Together these reach idle slots, zero-driven positions beyond the channel count, the single-wire index equal to the channel number, and back-to-back periods. In every configuration with more than one slot, an early strobe exercises the overrun path. Each slot of every period is compared with expected values computed from the channel arithmetic.

// File: rtl/tdm_sched_pkg.sv
package tdm_sched_pkg;
  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl #(
  parameter int TDM   = 3,
  parameter int SLOTW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  output logic             accept,
  output logic             busy_d,
  output logic [SLOTW-1:0] slot_d,
  output logic             overrun
);
  localparam logic [SLOTW-1:0] LAST = SLOTW'(TDM - 1);

  logic             busy_q;
  logic [SLOTW-1:0] slot_q;
  logic             clash;
  logic             ovr_d;
  logic             ovr_q;

  // a strobe is taken when idle or when the final slot is on the outputs
  assign accept = strobe && (!busy_q || slot_q == LAST);
  assign clash  = strobe && !accept;

  always_comb begin
    busy_d = busy_q;
    slot_d = slot_q;
    if (accept) begin
      busy_d = 1'b1;
      slot_d = '0;
    end else if (busy_q) begin
      if (slot_q == LAST) busy_d = 1'b0;
      else                slot_d = slot_q + 1'b1;
    end
    ovr_d = ovr_q | clash;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      slot_q <= slot_d;
      ovr_q  <= ovr_d;
    end
  end

  assign overrun = ovr_q;

  a_r6_restart_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_q && slot_q == '0));
  a_r7_flag_on_clash: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> overrun);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  a_r5_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ({1'b0, slot_q} < (SLOTW+1)'(TDM)));
endmodule

// File: rtl/tdm_sample_hold.sv
module tdm_sample_hold #(
  parameter int BITS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] din,
  output logic [BITS-1:0] hold_d,
  output logic [BITS-1:0] hold_q
);
  always_comb begin
    hold_d = hold_q;
    if (load) hold_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  a_r7_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hold_q));
endmodule

// File: rtl/tdm_wire_mux.sv
module tdm_wire_mux #(
  parameter int NUM_CH = 4,
  parameter int SW     = 8,
  parameter int NWIRE  = 2,
  parameter int CPW    = 2,
  parameter int SLOTW  = 2
) (
  input  logic [NUM_CH*SW-1:0] samples,
  input  logic [SLOTW-1:0]     slot,
  output logic [NWIRE*SW-1:0]  wires
);
  localparam int POS = NWIRE * CPW;

  // zero-padded copy so that positions past the last channel read as zero
  logic [POS*SW-1:0] padded;

  always_comb begin
    padded = '0;
    padded[NUM_CH*SW-1:0] = samples;
  end

  for (genvar w = 0; w < NWIRE; w++) begin : g_wire
    logic [SW-1:0] pick;
    always_comb begin
      pick = '0;
      for (int k = 0; k < CPW; k++) begin
        if (slot == SLOTW'(k)) pick = padded[(w*CPW + k)*SW +: SW];
      end
    end
    assign wires[w*SW +: SW] = pick;
  end
endmodule

// File: rtl/tdm_sched.sv
module tdm_sched
  import tdm_sched_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TDM    = 3,
  parameter int SW     = 8,
  localparam int NWIRE = ceil_div(NUM_CH, TDM),
  localparam int CPW   = ceil_div(NUM_CH, NWIRE),
  localparam int IDXW  = width_of(CPW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_strobe,
  input  logic [NUM_CH*SW-1:0] in_data,
  output logic                 out_valid,
  output logic [IDXW-1:0]      out_idx,
  output logic [NWIRE*SW-1:0]  out_data,
  output logic                 overrun
);
  localparam int SLOTW = width_of(TDM);
  localparam logic [SLOTW:0] CPW_W = (SLOTW+1)'(CPW);

  logic                 accept;
  logic                 busy_d;
  logic [SLOTW-1:0]     slot_d;
  logic [NUM_CH*SW-1:0] hold_d;
  logic [NUM_CH*SW-1:0] hold_q;
  logic [NWIRE*SW-1:0]  mux_out;
  logic                 live_d;
  logic                 valid_q;
  logic [IDXW-1:0]      idx_q;
  logic [NWIRE*SW-1:0]  data_q;

  tdm_slot_ctrl #(.TDM(TDM), .SLOTW(SLOTW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (in_strobe),
    .accept  (accept),
    .busy_d  (busy_d),
    .slot_d  (slot_d),
    .overrun (overrun)
  );

  tdm_sample_hold #(.BITS(NUM_CH*SW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .din    (in_data),
    .hold_d (hold_d),
    .hold_q (hold_q)
  );

  tdm_wire_mux #(
    .NUM_CH (NUM_CH),
    .SW     (SW),
    .NWIRE  (NWIRE),
    .CPW    (CPW),
    .SLOTW  (SLOTW)
  ) u_mux (
    .samples (hold_d),
    .slot    (slot_d),
    .wires   (mux_out)
  );

  assign live_d = busy_d && ({1'b0, slot_d} < CPW_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= live_d;
      idx_q   <= live_d ? IDXW'(slot_d) : '0;
      data_q  <= live_d ? mux_out : '0;
    end
  end

  assign out_valid = valid_q;
  assign out_idx   = idx_q;
  assign out_data  = data_q;

  a_r5_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_valid && out_idx == '0));
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_idx == '0 && out_data == '0));
  a_r1_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_idx} < (IDXW+1)'(CPW)));
  a_r1_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !accept && {1'b0, out_idx} < (IDXW+1)'(CPW - 1)) |=>
      (out_valid && out_idx == $past(out_idx) + 1'b1));
  a_r7_stable_data: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && !accept) |=> $stable(hold_q));
endmodule

// File: tb/tdm_sched_bench.sv
module tdm_sched_lane #(
  parameter int N = 4,
  parameter int T = 3,
  parameter int W = 8
) (
  input  logic clk,
  output int   runs,
  output int   fails,
  output logic done
);
  localparam int NW = (N + T - 1) / T;
  localparam int CP = (N + NW - 1) / NW;
  localparam int IW = (CP > 1) ? $clog2(CP) : 1;

  logic            rst_n;
  logic            stb;
  logic [N*W-1:0]  din;
  logic            vld;
  logic [IW-1:0]   idx;
  logic [NW*W-1:0] dout;
  logic            ov;
  bit              ov_exp;

  tdm_sched #(.NUM_CH(N), .TDM(T), .SW(W)) u_tdm_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_strobe (stb),
    .in_data   (din),
    .out_valid (vld),
    .out_idx   (idx),
    .out_data  (dout),
    .overrun   (ov)
  );

  function automatic logic [W-1:0] smp(input int p, input int c);
    return W'(p * 16 + c + 1);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s N=%0d T=%0d: actual %0d expected %0d", tag, N, T, act, exp);
    end
  endtask

  task automatic load(input int p);
    for (int c = 0; c < N; c++) din[c*W +: W] = smp(p, c);
    stb = 1'b1;
  endtask

  task automatic check_idle(input string tag);
    chk(tag, vld, 0);
    chk("R4", idx, 0);
    chk("R4", dout, 0);
    chk("R7", ov, ov_exp);
  endtask

  // walk through one period; optional back-to-back successor and early strobe
  task automatic period(input int p, input int nxt, input bit bb, input bit glitch);
    for (int k = 0; k < T; k++) begin
      @(negedge clk);
      stb = 1'b0;
      chk((k == 0 && bb) ? "R6" : ((k < CP) ? "R5" : "R4"), vld, k < CP);
      chk("R1", idx, (k < CP) ? k : 0);
      for (int w = 0; w < NW; w++) begin
        int ch = w * CP + k;
        chk((ch >= N && k < CP) ? "R3" : "R2", dout[w*W +: W],
            (k < CP && ch < N) ? smp(p, ch) : 0);
      end
      chk("R7", ov, ov_exp);
      if (glitch && k == 0) begin
        for (int c = 0; c < N; c++) din[c*W +: W] = smp(9, c);
        stb = 1'b1;
        ov_exp = 1'b1;
      end
      if (k == T - 1 && nxt >= 0) load(nxt);
    end
  endtask

  initial begin
    runs = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; stb = 1'b0; din = '0; ov_exp = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R8");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R4");
    load(1);
    period(1, 2, 1'b0, 1'b0);
    period(2, -1, 1'b1, 1'b0);
    @(negedge clk);
    check_idle("R5");
    @(negedge clk);
    check_idle("R5");
    load(3);
    period(3, -1, 1'b0, T > 1);
    @(negedge clk);
    stb = 1'b0;
    check_idle("R5");
    rst_n = 1'b0;
    ov_exp = 1'b0;
    @(negedge clk);
    check_idle("R8");
    rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
  end
endmodule

module tdm_sched_bench;
  logic clk;
  int   r [4];
  int   f [4];
  logic d [4];
  int   total;
  int   failed;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  tdm_sched_lane #(.N(2), .T(3), .W(8)) u_lane0 (.clk(clk), .runs(r[0]), .fails(f[0]), .done(d[0]));
  tdm_sched_lane #(.N(4), .T(3), .W(8)) u_lane1 (.clk(clk), .runs(r[1]), .fails(f[1]), .done(d[1]));
  tdm_sched_lane #(.N(5), .T(3), .W(8)) u_lane2 (.clk(clk), .runs(r[2]), .fails(f[2]), .done(d[2]));
  tdm_sched_lane #(.N(3), .T(1), .W(8)) u_lane3 (.clk(clk), .runs(r[3]), .fails(f[3]), .done(d[3]));

  initial begin
    int cyc;
    cyc = 0;
    total = 0;
    failed = 0;
    @(negedge clk);
    while (!(d[0] === 1'b1 && d[1] === 1'b1 && d[2] === 1'b1 && d[3] === 1'b1) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    for (int i = 0; i < 4; i++) begin
      total += r[i];
      failed += f[i];
    end
    if (cyc >= 20000) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("  [TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end
endmodule